// File: doc/BRIEF.md
# Two-Decoder Restricted-Term Logic Array

This block evaluates a programmable sum-of-products function whose product terms are limited per input group. The N-bit input is split into a low half `din[H-1:0]` and a high half `din[N-1:H]`, with H = N/2. Each half drives a fixed decoder that produces every product of exactly Q literals from that half, in every true/complement polarity. The decoder count per half is T = C(H,Q)·2^Q. Any final product can therefore hold up to 2Q literals, with at most Q from each half.

A first programmable OR plane folds the low-half terms into K intermediate sums. A cascade plane ANDs each intermediate sum with selected high-half terms. A final OR plane gathers those cascaded products into L outputs. All three planes are crosspoint enable registers, loaded one bit at a time through a write port. The logic runs as a two-stage pipeline that takes a new input vector every clock. A valid flag moves through the pipeline alongside the data.

Top module: `split_pla`

## Requirements
- R1: A synchronous active-high `rst` clears every crosspoint enable and every pipeline register. During reset and on the clock edge that follows it, `dout` and `valid_out` read 0. After reset, with no writes, `dout` stays 0 for any input.
- R2: Decoder term index t = rank·2^Q + pol. `rank` counts Q-variable index combinations in lexicographic order: (0,1), (0,2), … for Q=2. Bit j of `pol` gives the polarity of the j-th lowest chosen variable, where 1 means true and 0 means complement. A term is 1 exactly when every one of its literals holds.
- R3: Intermediate sum k is the OR of the low-half terms t whose first-plane crosspoint (row k, column t) is enabled.
- R4: Cascaded product j = k·T + t is sum k AND high-half term t, gated by the cascade crosspoint (row k, column t).
- R5: Output l is the OR of the cascaded products j whose output-plane crosspoint (row l, column j) is enabled.
- R6: A new input may be applied every cycle. The result for an input sampled at clock edge e appears on `dout` after edge e+1.
- R7: `valid_out` equals `valid_in` as sampled two clock edges earlier.
- R8: `dout` has LP = L rounded up to even bits. When L is odd, the top bit is padding and always reads 0.
- R9: A write with `wr_en` high sets the addressed crosspoint to `wr_data`. `wr_plane` selects the plane: 0 is the first OR plane, 1 is the cascade plane, 2 is the output plane, and 3 is ignored. A write whose row or column lies outside the selected plane's size changes nothing. A write takes effect for every input sampled after the write cycle.
- R10: A write with `wr_data` = 0 clears a previously set crosspoint. Only the addressed crosspoint changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | N | Input vector; low half to decoder A, high half to decoder B |
| valid_in | input | 1 | Marks `din` as a valid sample |
| wr_en | input | 1 | Crosspoint write strobe |
| wr_plane | input | 2 | Plane select (0 first OR, 1 cascade, 2 output, 3 none) |
| wr_row | input | RW | Row address: sum index k or output index l |
| wr_col | input | CW | Column address: term t, or product j for the output plane |
| wr_data | input | 1 | Value written to the crosspoint |
| dout | output | LP | Registered outputs, padded to an even count |
| valid_out | output | 1 | Valid flag aligned with `dout` |

## Verification
Every output is due after the second clock edge following the edge that samples its input, so the bench holds a two-deep history of applied inputs and valid flags. Inputs are driven on the falling edge. Each falling edge first compares `dout`, `valid_out` and the padding bit against the model evaluated on the input from two falling edges earlier, then applies the next input. Crosspoint writes are followed by idle cycles before any sweep starts, so each sweep runs against a settled configuration. Each sweep covers all 256 input vectors of the N=8, Q=2 configuration.

// File: rtl/split_pla_pkg.sv
package split_pla_pkg;

  // Binomial coefficient, integer arithmetic only.
  function automatic int binom(input int n, input int k);
    int r;
    if (k < 0 || k > n) return 0;
    r = 1;
    for (int i = 1; i <= k; i++) r = r * (n - k + i) / i;
    return r;
  endfunction

  // Variable index at position pos of the combination with lexicographic rank.
  function automatic int comb_pick(input int h, input int q, input int rank, input int pos);
    int rem;
    int base;
    int sel;
    bit found;
    rem  = rank;
    base = 0;
    sel  = 0;
    for (int p = 0; p < q; p++) begin
      found = 1'b0;
      for (int c = 0; c < h; c++) begin
        if (c >= base && !found) begin
          if (rem < binom(h - 1 - c, q - 1 - p)) begin
            sel   = c;
            found = 1'b1;
          end else begin
            rem = rem - binom(h - 1 - c, q - 1 - p);
          end
        end
      end
      if (p == pos) return sel;
      base = sel + 1;
    end
    return 0;
  endfunction

endpackage

// File: rtl/split_pla_dec.sv
// Fixed AND plane: all Q-literal products over one input half.
module split_pla_dec #(
  parameter int H = 4,
  parameter int Q = 2,
  parameter int T = split_pla_pkg::binom(H, Q) << Q
) (
  input  logic [H-1:0] x,
  output logic [T-1:0] term
);
  localparam int NPOL = 1 << Q;

  for (genvar t = 0; t < T; t++) begin : g_term
    localparam int RANK = t / NPOL;
    localparam int POL  = t % NPOL;
    logic [Q-1:0] lit;
    for (genvar p = 0; p < Q; p++) begin : g_lit
      localparam int VAR = split_pla_pkg::comb_pick(H, Q, RANK, p);
      if (((POL >> p) & 1) != 0) begin : g_true
        assign lit[p] = x[VAR];
      end else begin : g_comp
        assign lit[p] = ~x[VAR];
      end
    end
    assign term[t] = &lit;
  end
endmodule

// File: rtl/split_pla_orplane.sv
// Programmable OR plane: ROWS outputs over COLS inputs.
module split_pla_orplane #(
  parameter int ROWS = 4,
  parameter int COLS = 24
) (
  input  logic [COLS-1:0]      in,
  input  logic [ROWS*COLS-1:0] en,
  output logic [ROWS-1:0]      y
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign y[r] = |(in & en[r*COLS +: COLS]);
  end
endmodule

// File: rtl/split_pla_xpt.sv
// Crosspoint enable store for the three programmable planes.
module split_pla_xpt #(
  parameter int K  = 4,
  parameter int L  = 3,
  parameter int T  = 24,
  parameter int RW = 2,
  parameter int CW = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_plane,
  input  logic [RW-1:0]      wr_row,
  input  logic [CW-1:0]      wr_col,
  input  logic               wr_data,
  output logic [K*T-1:0]     or1_en,
  output logic [K*T-1:0]     cas_en,
  output logic [L*K*T-1:0]   out_en
);
  localparam int KT = K * T;

  logic hit0, hit1, hit2;
  int   addr_small, addr_big;
  logic [KT-1:0]   or1_nx, cas_nx;
  logic [L*KT-1:0] out_nx;

  always_comb begin
    hit0 = wr_en && (wr_plane == 2'd0) && (int'(wr_row) < K) && (int'(wr_col) < T);
    hit1 = wr_en && (wr_plane == 2'd1) && (int'(wr_row) < K) && (int'(wr_col) < T);
    hit2 = wr_en && (wr_plane == 2'd2) && (int'(wr_row) < L) && (int'(wr_col) < KT);
    addr_small = int'(wr_row) * T + int'(wr_col);
    addr_big   = int'(wr_row) * KT + int'(wr_col);
  end

  for (genvar i = 0; i < KT; i++) begin : g_small
    assign or1_nx[i] = (hit0 && addr_small == i) ? wr_data : or1_en[i];
    assign cas_nx[i] = (hit1 && addr_small == i) ? wr_data : cas_en[i];
  end
  for (genvar i = 0; i < L*KT; i++) begin : g_big
    assign out_nx[i] = (hit2 && addr_big == i) ? wr_data : out_en[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      or1_en <= '0;
      cas_en <= '0;
      out_en <= '0;
    end else begin
      or1_en <= or1_nx;
      cas_en <= cas_nx;
      out_en <= out_nx;
    end
  end

  AST_PLANE3_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_plane == 2'd3) |=> ($stable(or1_en) && $stable(cas_en) && $stable(out_en))); // R9
endmodule

// File: rtl/split_pla.sv
module split_pla #(
  parameter int N = 8,
  parameter int Q = 2,
  parameter int L = 3,
  parameter int K = 4,
  localparam int H  = N / 2,
  localparam int T  = split_pla_pkg::binom(H, Q) << Q,
  localparam int KT = K * T,
  localparam int MR = (K > L) ? K : L,
  localparam int RW = (MR > 1) ? $clog2(MR) : 1,
  localparam int CW = (KT > 1) ? $clog2(KT) : 1,
  localparam int LP = L + (L % 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  din,
  input  logic          valid_in,
  input  logic          wr_en,
  input  logic [1:0]    wr_plane,
  input  logic [RW-1:0] wr_row,
  input  logic [CW-1:0] wr_col,
  input  logic          wr_data,
  output logic [LP-1:0] dout,
  output logic          valid_out
);
  localparam int NCOMB = split_pla_pkg::binom(H, Q);

  logic [T-1:0]    term_a, term_b;
  logic [KT-1:0]   or1_en, cas_en;
  logic [L*KT-1:0] out_en;
  logic [K-1:0]    sum_a;
  logic [K-1:0]    s1_sum;
  logic [T-1:0]    s1_tb;
  logic            s1_v;
  logic [KT-1:0]   prod;
  logic [L-1:0]    y_out;
  logic [L-1:0]    dout_q;
  logic            v2_q;

  split_pla_xpt #(.K(K), .L(L), .T(T), .RW(RW), .CW(CW)) xpt_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_plane(wr_plane),
    .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data),
    .or1_en(or1_en), .cas_en(cas_en), .out_en(out_en)
  );

  split_pla_dec #(.H(H), .Q(Q), .T(T)) dec_a_i (.x(din[H-1:0]), .term(term_a));
  split_pla_dec #(.H(H), .Q(Q), .T(T)) dec_b_i (.x(din[N-1:H]), .term(term_b));

  split_pla_orplane #(.ROWS(K), .COLS(T)) or1_i (.in(term_a), .en(or1_en), .y(sum_a));

  // Stage 1: intermediate sums and the high-half terms.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_sum <= '0;
      s1_tb  <= '0;
      s1_v   <= 1'b0;
    end else begin
      s1_sum <= sum_a;
      s1_tb  <= term_b;
      s1_v   <= valid_in;
    end
  end

  // Cascade plane: each sum ANDed with each enabled high-half term.
  for (genvar k = 0; k < K; k++) begin : g_cas
    assign prod[k*T +: T] = {T{s1_sum[k]}} & s1_tb & cas_en[k*T +: T];
  end

  split_pla_orplane #(.ROWS(L), .COLS(KT)) or2_i (.in(prod), .en(out_en), .y(y_out));

  // Stage 2: registered outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      v2_q   <= 1'b0;
    end else begin
      dout_q <= y_out;
      v2_q   <= s1_v;
    end
  end

  if (LP > L) begin : g_pad
    assign dout = {1'b0, dout_q};
  end else begin : g_nopad
    assign dout = dout_q;
  end
  assign valid_out = v2_q;

  AST_TERM_COUNT_A: assert property (@(posedge clk) disable iff (rst)
    ($countones(term_a) == NCOMB)); // R2
  AST_TERM_COUNT_B: assert property (@(posedge clk) disable iff (rst)
    ($countones(term_b) == NCOMB)); // R2
  AST_VALID_STAGE1: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> s1_v); // R7
  AST_VALID_STAGE2: assert property (@(posedge clk) disable iff (rst)
    s1_v |=> valid_out); // R7
  AST_OUT_NEEDS_PROD: assert property (@(posedge clk) disable iff (rst)
    (|dout_q) |-> $past(|prod)); // R5
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (dout == '0 && !valid_out)); // R1
endmodule

// File: tb/split_pla_tb_top.sv
`timescale 1ns/1ps
module split_pla_tb_top;
  // Bench configuration is fixed at N=8, Q=2, L=3, K=4.
  localparam int N = 8, Q = 2, L = 3, K = 4;
  localparam int H = 4, T = 24, KT = 96, LP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] din = '0;
  logic valid_in = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_plane = '0;
  logic [1:0] wr_row = '0;
  logic [6:0] wr_col = '0;
  logic wr_data = 1'b0;
  logic [LP-1:0] dout;
  logic valid_out;

  int n_tests = 0;
  int n_fail  = 0;

  bit m_or1 [K][T];
  bit m_cas [K][T];
  bit m_out [L][KT];

  always #5 clk = ~clk;

  split_pla #(.N(N), .Q(Q), .L(L), .K(K)) dut_i (
    .clk(clk), .rst(rst), .din(din), .valid_in(valid_in),
    .wr_en(wr_en), .wr_plane(wr_plane), .wr_row(wr_row), .wr_col(wr_col),
    .wr_data(wr_data), .dout(dout), .valid_out(valid_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // Q=2 decoder: pairs (a<b) in lexicographic order, pol bit0 -> a, bit1 -> b.
  function automatic logic [T-1:0] ref_terms(input logic [H-1:0] x);
    logic [T-1:0] r;
    int idx;
    idx = 0;
    r = '0;
    for (int a = 0; a < H; a++)
      for (int b = a + 1; b < H; b++)
        for (int p = 0; p < 4; p++) begin
          r[idx] = (x[a] == p[0]) && (x[b] == p[1]);
          idx++;
        end
    return r;
  endfunction

  function automatic logic [LP-1:0] ref_out(input logic [N-1:0] x);
    logic [T-1:0] ta, tb;
    logic [K-1:0] s;
    logic [KT-1:0] pr;
    logic [LP-1:0] o;
    ta = ref_terms(x[H-1:0]);
    tb = ref_terms(x[N-1:H]);
    s = '0;
    for (int k = 0; k < K; k++)
      for (int t = 0; t < T; t++)
        if (m_or1[k][t] && ta[t]) s[k] = 1'b1;
    for (int k = 0; k < K; k++)
      for (int t = 0; t < T; t++)
        pr[k*T+t] = s[k] && tb[t] && m_cas[k][t];
    o = '0;
    for (int l = 0; l < L; l++)
      for (int j = 0; j < KT; j++)
        if (m_out[l][j] && pr[j]) o[l] = 1'b1;
    return o;
  endfunction

  task automatic clear_model();
    for (int k = 0; k < K; k++) for (int t = 0; t < T; t++) begin
      m_or1[k][t] = 1'b0;
      m_cas[k][t] = 1'b0;
    end
    for (int l = 0; l < L; l++) for (int j = 0; j < KT; j++) m_out[l][j] = 1'b0;
  endtask

  task automatic wr(input int plane, input int row, input int col, input bit d);
    @(negedge clk);
    wr_en    = 1'b1;
    wr_plane = plane[1:0];
    wr_row   = row[1:0];
    wr_col   = col[6:0];
    wr_data  = d;
    if (plane == 0 && row < K && col < T) m_or1[row][col] = d;
    if (plane == 1 && row < K && col < T) m_cas[row][col] = d;
    if (plane == 2 && row < L && col < KT) m_out[row][col] = d;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    wr_en = 1'b0;
    valid_in = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic program_cfg(input int d1, input int d2, input int d3);
    for (int k = 0; k < K; k++) for (int t = 0; t < T; t++) wr(0, k, t, ($urandom % d1) == 0);
    for (int k = 0; k < K; k++) for (int t = 0; t < T; t++) wr(1, k, t, ($urandom % d2) == 0);
    for (int l = 0; l < L; l++) for (int j = 0; j < KT; j++) wr(2, l, j, ($urandom % d3) == 0);
    idle(3);
  endtask

  // Exhaustive stream: one new input per cycle, result checked two cycles later.
  task automatic sweep(input string tag, input bit rnd_valid);
    logic [N-1:0] hx [2];
    logic hv [2];
    for (int i = 0; i < 258; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk(dout === ref_out(hx[0]), tag, 32'(dout), 32'(ref_out(hx[0])));
        chk(valid_out === hv[0], "R7 valid latency", 32'(valid_out), 32'(hv[0]));
        chk(dout[LP-1] === 1'b0, "R8 pad bit", 32'(dout[LP-1]), 32'd0);
      end
      hx[0] = hx[1];
      hv[0] = hv[1];
      din = (i < 256) ? 8'(i) : 8'h00;
      valid_in = rnd_valid ? 1'($urandom % 2) : (i < 256);
      hx[1] = din;
      hv[1] = valid_in;
    end
    idle(2);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #2000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(dout === '0, "R1 dout in reset", 32'(dout), 0);
    chk(valid_out === 1'b0, "R1 valid_out in reset", 32'(valid_out), 0);
    @(negedge clk);
    rst = 1'b0;
    // R1: no enables after reset, all outputs stay 0
    sweep("R1 cleared planes", 1'b0);

    // R2 R3 R4 R5 R6: sparse random configuration
    program_cfg(4, 4, 16);
    sweep("R2 R3 R4 R5 R6 sparse", 1'b1);

    // R10: overwrite with another pattern, clearing many crosspoints
    program_cfg(3, 3, 10);
    sweep("R10 rewrite", 1'b0);

    // R8: dense planes drive real outputs high, pad stays 0
    program_cfg(1, 1, 2);
    sweep("R8 dense", 1'b1);

    // R9: ignored plane and out-of-range addresses leave the model unchanged
    program_cfg(4, 4, 16);
    for (int r = 0; r < 4; r++) for (int c = 0; c < 128; c++) wr(3, r, c, 1'b1);
    for (int r = 0; r < 4; r++) for (int c = T; c < 128; c++) wr(0, r, c, 1'b1);
    for (int r = 0; r < 4; r++) for (int c = T; c < 128; c++) wr(1, r, c, 1'b1);
    for (int c = 0; c < 128; c++) wr(2, 3, c, 1'b1);
    for (int r = 0; r < L; r++) for (int c = KT; c < 128; c++) wr(2, r, c, 1'b1);
    idle(3);
    sweep("R9 ignored writes", 1'b0);

    // R1: reset after programming clears every plane
    program_cfg(1, 1, 2);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(dout === '0, "R1 dout after re-reset", 32'(dout), 0);
    rst = 1'b0;
    clear_model();
    sweep("R1 planes cleared by reset", 1'b1);

    finish_run();
  end
endmodule